// File: doc/BRIEF.md
# I2C Target Port with Double-Buffered Receive

This block answers as a target on a two-wire I2C bus and presents its traffic to a host through a small 16-bit register window. It compares incoming addresses against a stored own address of either 7 or 10 bits, selected by a control bit. Serial bits are collected in a shifter. Each finished data byte is moved into a separate holding buffer, and a one-cycle interrupt pulse goes out when that happens. For read transfers the host loads a byte into a send register, and the block shifts it out MSB first. The block can keep SCL low until the host has supplied data, or until the host writes a release bit.

The host side is a flat register window with four word locations, selected by a 2-bit index: 0 control, 1 status, 2 own address, 3 data. Reading location 3 returns the buffered receive byte. Writing location 3 fills the send register. The bus side uses open-drain enables: a 1 on `scl_oe` or `sda_oe` pulls that line low. Both incoming lines pass through a two-stage synchronizer before any decision is taken.

Top module: `i2cs_top`

## Requirements
- R1: A START (SDA falling while SCL is high) sets status bit 5 (bus busy). A STOP (SDA rising while SCL is high) clears status bit 5. While status bit 5 is clear, the block drives neither `sda_oe` nor `scl_oe`.
- R2: With control bit 1 = 0, the first byte after START is ACKed (SDA held low during the ninth clock) only when its upper seven bits equal own-address bits 6:0. On a mismatch the block NACKs and ignores later bytes until the next START, so no interrupt is raised.
- R3: With control bit 1 = 1, a write header of 11110, then own-address bits 9:8, then 0, is ACKed. It must be followed by a byte equal to own-address bits 7:0, which is also ACKed. A wrong header or a wrong second byte is NACKed.
- R4: In 10-bit mode, a read header (11110, bits 9:8, then 1) is ACKed only if a full 10-bit write match has occurred since the last STOP, as after a repeated START.
- R5: After an address match for writing, each completed data byte goes to the receive buffer and is ACKed. Status bit 0 (buffer full) sets, and `irq` is high for exactly one clock cycle. Reading location 3 returns the byte and clears status bit 0.
- R6: A data byte that completes while status bit 0 is set is NACKed and leaves the buffer unchanged. It sets status bit 6 (overflow), which stays set until the host writes 0 to that bit.
- R7: On a read transfer, the byte written to location 3 is sent MSB first. Status bit 1 shows that the send register holds a byte not yet taken.
- R8: After ACKing a read address, and after each sent byte that the controller ACKs, SCL is held low while the send register is empty. Status bit 4 shows the hold. SCL is freed once location 3 is written.
- R9: A controller NACK on a sent byte ends the read transfer and sets status bit 7. That bit stays set until the host writes 0 to it.
- R10: With control bit 2 = 1, SCL is held low after each accepted received byte. The hold ends once the host writes control bit 3 = 1. Hardware clears control bit 3 when the hold begins.
- R11: All 16 control bits read back as written, apart from the hardware clear of bit 3. Writes to the status word affect only bits 7:6. Bits 5:0 are read-only.
- R12: With control bit 0 (enable) = 0, the block ignores bus traffic: it gives no ACK and reports no busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe; a read of location 3 consumes the receive buffer |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register index (0 control, 1 status, 2 own address, 3 data) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the indexed register |
| irq | output | 1 | One-cycle pulse per byte placed in the receive buffer |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets the overflow case. A design that overwrote the buffer would return the second byte instead of the first, and a design that ACKed would hide the loss from the controller. It also exercises a 10-bit read header sent with and without a prior full match. A decoder that looked only at the header would answer a read it was never addressed for. Clock holding is checked in both places it occurs: while waiting for send data, and while waiting for the release bit. A design that freed SCL early would clock out a stale byte, or let the controller run past an unread buffer. A controller NACK must end the read; otherwise the target would keep driving SDA into the STOP.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_OWN  = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_RX,
        ST_TX
    } eng_st_e;

    // low four control bits, en at bit 0
    typedef struct packed {
        logic rel;
        logic stretch;
        logic ten;
        logic en;
    } ctrl_t;

    // single-cycle requests from the engine to the register file
    typedef struct packed {
        logic rx_push;
        logic ovf_set;
        logic tx_pop;
        logic hold_clr;
        logic nack_set;
    } eng_ev_t;

    typedef struct packed {
        logic busy;
        logic hold;
        logic sel;
        logic rw;
    } eng_stat_t;

    function automatic logic [7:0] ten_header(input logic [1:0] hi, input logic rw);
        return {TEN_PREFIX, hi, rw};
    endfunction

endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe;
    logic [MSB:0] sda_pipe;
    logic         scl_d;
    logic         sda_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
                    sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_pipe[MSB];
            sda_d <= sda_pipe[MSB];
        end
    end

    assign scl_s     = scl_pipe[MSB];
    assign sda_s     = sda_pipe[MSB];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] own,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic [7:0]        tx_data,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output eng_ev_t           ev,
    output eng_stat_t         stat,
    output logic [7:0]        rx_byte,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam logic [3:0] BIT_LAST = 4'd7;
    localparam logic [3:0] BIT_ACK  = 4'd8;
    localparam logic [3:0] BIT_END  = 4'd9;

    eng_st_e    st;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       sda_drv;
    logic       scl_hold;
    logic       hold_tx;
    logic       ack_ok;
    logic       rw;
    logic       sel;
    logic       ten_full;
    logic       busy;
    logic [7:0] nb;
    logic       hdr_ok;

    assign nb     = {shreg[6:0], sda_s};
    assign hdr_ok = (nb[7:1] == ten_header(own[9:8], 1'b0) >> 1);

    always_ff @(posedge clk) begin
        ev <= '0;
        if (rst || !ctrl.en) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            sda_drv  <= 1'b0;
            scl_hold <= 1'b0;
            hold_tx  <= 1'b0;
            ack_ok   <= 1'b0;
            rw       <= 1'b0;
            sel      <= 1'b0;
            ten_full <= 1'b0;
            busy     <= 1'b0;
        end else if (start_det) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_drv  <= 1'b0;
            scl_hold <= 1'b0;
            sel      <= 1'b0;
            busy     <= 1'b1;
        end else if (stop_det) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            sda_drv  <= 1'b0;
            scl_hold <= 1'b0;
            sel      <= 1'b0;
            ten_full <= 1'b0;
            busy     <= 1'b0;
        end else if (scl_hold) begin
            if (hold_tx && tx_full) begin
                shreg      <= tx_data;
                sda_drv    <= ~tx_data[7];
                ev.tx_pop  <= 1'b1;
                scl_hold   <= 1'b0;
            end else if (!hold_tx && ctrl.rel && !ev.hold_clr) begin
                scl_hold <= 1'b0;
            end
        end else if (st != ST_IDLE) begin
            if (scl_rise) begin
                if (bitcnt != BIT_END) bitcnt <= bitcnt + 4'd1;
                if (st != ST_TX && bitcnt <= BIT_LAST) shreg <= nb;
                if (st != ST_TX && bitcnt == BIT_LAST) begin
                    case (st)
                        ST_ADDR: begin
                            rw <= nb[0];
                            if (!ctrl.ten)
                                ack_ok <= (nb[7:1] == own[6:0]);
                            else if (!nb[0])
                                ack_ok <= hdr_ok;
                            else
                                ack_ok <= hdr_ok && ten_full;
                        end
                        ST_ADDR2: ack_ok <= (nb == own[7:0]);
                        default: begin
                            if (rx_full) begin
                                ev.ovf_set <= 1'b1;
                                ack_ok     <= 1'b0;
                            end else begin
                                ev.rx_push <= 1'b1;
                                ack_ok     <= 1'b1;
                            end
                        end
                    endcase
                end
                if (st == ST_TX && bitcnt == BIT_ACK) begin
                    ack_ok      <= ~sda_s;
                    ev.nack_set <= sda_s;
                end
            end else if (scl_fall) begin
                if (bitcnt == BIT_ACK) begin
                    sda_drv <= (st == ST_TX) ? 1'b0 : ack_ok;
                end else if (bitcnt == BIT_END) begin
                    bitcnt  <= '0;
                    sda_drv <= 1'b0;
                    case (st)
                        ST_ADDR: begin
                            if (!ack_ok) begin
                                st <= ST_IDLE;
                            end else if (ctrl.ten && !rw) begin
                                st <= ST_ADDR2;
                            end else if (rw) begin
                                sel <= 1'b1;
                                st  <= ST_TX;
                                if (tx_full) begin
                                    shreg     <= tx_data;
                                    sda_drv   <= ~tx_data[7];
                                    ev.tx_pop <= 1'b1;
                                end else begin
                                    scl_hold <= 1'b1;
                                    hold_tx  <= 1'b1;
                                end
                            end else begin
                                sel <= 1'b1;
                                st  <= ST_RX;
                            end
                        end
                        ST_ADDR2: begin
                            if (ack_ok) begin
                                ten_full <= 1'b1;
                                sel      <= 1'b1;
                                st       <= ST_RX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_RX: begin
                            if (ack_ok && ctrl.stretch) begin
                                scl_hold    <= 1'b1;
                                hold_tx     <= 1'b0;
                                ev.hold_clr <= 1'b1;
                            end
                        end
                        ST_TX: begin
                            if (!ack_ok) begin
                                st  <= ST_IDLE;
                                sel <= 1'b0;
                            end else if (tx_full) begin
                                shreg     <= tx_data;
                                sda_drv   <= ~tx_data[7];
                                ev.tx_pop <= 1'b1;
                            end else begin
                                scl_hold <= 1'b1;
                                hold_tx  <= 1'b1;
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end else if (st == ST_TX && bitcnt != 4'd0) begin
                    shreg   <= {shreg[6:0], 1'b0};
                    sda_drv <= ~shreg[6];
                end
            end
        end
    end

    assign stat    = '{busy: busy, hold: scl_hold, sel: sel, rw: rw};
    assign rx_byte = shreg;
    assign scl_oe  = scl_hold;
    assign sda_oe  = sda_drv;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    input  eng_ev_t           ev,
    input  eng_stat_t         stat,
    input  logic [7:0]        rx_byte,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] own,
    output logic              rx_full,
    output logic [7:0]        rx_data,
    output logic              tx_full,
    output logic [7:0]        tx_data,
    output logic              ovf_flag,
    output logic              irq
);
    localparam int STAT_PAD = BUS_W - 8;
    localparam int OWN_PAD  = BUS_W - ADDR_W;
    localparam int DATA_PAD = BUS_W - 8;

    logic [BUS_W-1:0] ctrl_q;
    logic             nack_flag;
    logic             wr_ctrl, wr_stat, wr_own, wr_data, rd_data;

    assign wr_ctrl = host_wr && host_addr == REG_CTRL;
    assign wr_stat = host_wr && host_addr == REG_STAT;
    assign wr_own  = host_wr && host_addr == REG_OWN;
    assign wr_data = host_wr && host_addr == REG_DATA;
    assign rd_data = host_rd && host_addr == REG_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            own       <= '0;
            rx_full   <= 1'b0;
            rx_data   <= '0;
            tx_full   <= 1'b0;
            tx_data   <= '0;
            ovf_flag  <= 1'b0;
            nack_flag <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_ctrl) ctrl_q <= host_wdata;
            if (ev.hold_clr) ctrl_q[3] <= 1'b0;
            if (wr_own) own <= host_wdata[ADDR_W-1:0];

            if (rd_data) rx_full <= 1'b0;
            if (ev.rx_push && !rx_full) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
                irq     <= 1'b1;
            end

            if (ev.tx_pop) tx_full <= 1'b0;
            if (wr_data) begin
                tx_data <= host_wdata[7:0];
                tx_full <= 1'b1;
            end

            if (wr_stat) begin
                ovf_flag  <= host_wdata[6];
                nack_flag <= host_wdata[7];
            end
            if (ev.ovf_set)  ovf_flag  <= 1'b1;
            if (ev.nack_set) nack_flag <= 1'b1;
        end
    end

    assign ctrl = ctrl_t'(ctrl_q[3:0]);

    always_comb begin
        case (host_addr)
            REG_CTRL: host_rdata = ctrl_q;
            REG_STAT: host_rdata = {{STAT_PAD{1'b0}}, nack_flag, ovf_flag, stat.busy,
                                    stat.hold, stat.sel, stat.rw, tx_full, rx_full};
            REG_OWN:  host_rdata = {{OWN_PAD{1'b0}}, own};
            default:  host_rdata = {{DATA_PAD{1'b0}}, rx_data};
        endcase
    end

endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [1:0]       host_addr,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    output logic             irq,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] own;
    logic              rx_full, tx_full, ovf_flag;
    logic [7:0]        rx_data, tx_data, rx_byte;
    eng_ev_t           ev;
    eng_stat_t         stat;
    logic              st_sel, st_busy;

    i2cs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst(rst), .ctrl(ctrl), .own(own),
        .rx_full(rx_full), .tx_full(tx_full), .tx_data(tx_data),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .ev(ev), .stat(stat), .rx_byte(rx_byte),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    i2cs_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev(ev), .stat(stat), .rx_byte(rx_byte),
        .ctrl(ctrl), .own(own), .rx_full(rx_full), .rx_data(rx_data),
        .tx_full(tx_full), .tx_data(tx_data), .ovf_flag(ovf_flag), .irq(irq)
    );

    assign st_sel  = stat.sel;
    assign st_busy = stat.busy;

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       rx_full,
    input logic [7:0] rx_data,
    input logic       ovf_flag,
    input logic       host_rd,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       st_sel,
    input logic       st_busy
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R5
    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (rst) irq |-> rx_full); // R5
    AST_BUF_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !(host_rd && host_addr == REG_DATA)) |=> $stable(rx_data)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(host_wr && host_addr == REG_STAT)) |=> ovf_flag); // R6
    AST_HOLD_SELECTED: assert property (@(posedge clk) disable iff (rst) scl_oe |-> st_sel); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !st_busy |-> (!sda_oe && !scl_oe)); // R1
endmodule

bind i2cs_top i2cs_chk chk_i (
    .clk(clk), .rst(rst), .irq(irq), .rx_full(rx_full), .rx_data(rx_data),
    .ovf_flag(ovf_flag), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .st_sel(st_sel), .st_busy(st_busy)
);

// File: tb/i2cs_top_tb_top.sv
`timescale 1ns/1ps
module i2cs_top_tb_top;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        irq, scl_oe, sda_oe;
    logic        m_scl_low = 1'b0;
    logic        m_sda_low = 1'b0;
    wire         scl_line = ~(m_scl_low | scl_oe);
    wire         sda_line = ~(m_sda_low | sda_oe);

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;

    always #2.5 clk = ~clk;

    i2cs_top dut_i (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(posedge clk) if (!rst && irq === 1'b1) irq_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hw(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic wait_scl_high;
        @(posedge clk); #1;
        while (scl_line !== 1'b1) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic m_bit_w(input logic b);
        m_sda_low = ~b; wq(Q);
        m_scl_low = 1'b0; wait_scl_high; wq(2 * Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_bit_r(output logic b);
        m_sda_low = 1'b0; wq(Q);
        m_scl_low = 1'b0; wait_scl_high; wq(Q);
        b = sda_line; wq(Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_start;
        m_sda_low = 1'b0; wq(Q);
        m_scl_low = 1'b0; wait_scl_high; wq(2 * Q);
        m_sda_low = 1'b1; wq(2 * Q);
        m_scl_low = 1'b1; wq(Q);
    endtask

    task automatic m_stop;
        m_sda_low = 1'b1; wq(Q);
        m_scl_low = 1'b0; wait_scl_high; wq(2 * Q);
        m_sda_low = 1'b0; wq(2 * Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit_w(b[i]);
        m_bit_r(s);
        ack = ~s;
    endtask

    task automatic m_rbyte(output logic [7:0] b, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit_r(s);
            b[i] = s;
        end
        m_bit_w(~give_ack);
        m_sda_low = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        hr(2'd1, d); chk("R11 reset status", d, 16'h0000);
        hr(2'd0, d); chk("R11 reset control", d, 16'h0000);
        chk("R1 reset bus outputs", {scl_oe, sda_oe, irq}, 3'b000);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        hw(2'd0, 16'hA5F2); hr(2'd0, d); chk("R11 control readback", d, 16'hA5F2);
        hw(2'd1, 16'hFFFF); hr(2'd1, d); chk("R11 status write upper only", d, 16'h00C0);
        hw(2'd1, 16'h0000); hr(2'd1, d); chk("R11 status clear", d, 16'h0000);
    endtask

    task automatic t_disabled;
        logic ack;
        logic [15:0] d;
        hw(2'd0, 16'h0000); hw(2'd2, 16'h0042);
        m_start;
        hr(2'd1, d); chk("R12 no busy when disabled", d[5], 1'b0);
        m_wbyte(8'h84, ack); chk("R12 no ack when disabled", ack, 1'b0);
        m_stop;
    endtask

    task automatic t_write7;
        logic ack;
        logic [15:0] d;
        int c0;
        hw(2'd0, 16'h0001);
        m_start;
        hr(2'd1, d); chk("R1 busy after start", d[5], 1'b1);
        m_wbyte(8'h84, ack); chk("R2 address ack", ack, 1'b1);
        hr(2'd1, d); chk("R2 selected flag", d[3], 1'b1);
        c0 = irq_cnt;
        m_wbyte(8'h5A, ack); chk("R5 data ack", ack, 1'b1);
        chk("R5 one irq pulse", irq_cnt - c0, 1);
        hr(2'd1, d); chk("R5 buffer full flag", d[0], 1'b1);
        hr(2'd3, d); chk("R5 receive data", d, 16'h005A);
        hr(2'd1, d); chk("R5 full flag cleared by read", d[0], 1'b0);
        m_stop;
        hr(2'd1, d); chk("R1 busy cleared by stop", d[5], 1'b0);
    endtask

    task automatic t_mismatch;
        logic ack;
        int c0;
        c0 = irq_cnt;
        m_start;
        m_wbyte(8'h86, ack); chk("R2 mismatch nack", ack, 1'b0);
        m_wbyte(8'hFF, ack); chk("R2 later byte ignored", ack, 1'b0);
        chk("R2 no irq after mismatch", irq_cnt - c0, 0);
        m_stop;
    endtask

    task automatic t_overflow;
        logic ack;
        logic [15:0] d;
        int c0;
        m_start;
        m_wbyte(8'h84, ack);
        m_wbyte(8'h11, ack); chk("R5 first byte ack", ack, 1'b1);
        c0 = irq_cnt;
        m_wbyte(8'h22, ack); chk("R6 overflow byte nacked", ack, 1'b0);
        chk("R6 no irq on overflow", irq_cnt - c0, 0);
        hr(2'd1, d); chk("R6 overflow flag", d[6], 1'b1);
        hr(2'd3, d); chk("R6 buffer kept first byte", d, 16'h0011);
        m_stop;
        hr(2'd1, d); chk("R6 overflow sticky", d[6], 1'b1);
        hw(2'd1, 16'h0000); hr(2'd1, d); chk("R6 overflow cleared by host", d[6], 1'b0);
    endtask

    task automatic t_ten;
        logic ack;
        logic [15:0] d;
        hw(2'd0, 16'h0003); hw(2'd2, 16'h02A5);
        m_start;
        m_wbyte(8'hF4, ack); chk("R3 header ack", ack, 1'b1);
        m_wbyte(8'hA5, ack); chk("R3 low byte ack", ack, 1'b1);
        m_wbyte(8'h3C, ack); chk("R3 data ack", ack, 1'b1);
        hr(2'd3, d); chk("R3 data received", d, 16'h003C);
        m_stop;
        m_start;
        m_wbyte(8'hF4, ack);
        m_wbyte(8'hA4, ack); chk("R3 wrong low byte nack", ack, 1'b0);
        m_stop;
        m_start;
        m_wbyte(8'hF2, ack); chk("R3 wrong header nack", ack, 1'b0);
        m_stop;
    endtask

    task automatic t_ten_read;
        logic ack;
        logic [7:0] b;
        logic [15:0] d;
        hw(2'd1, 16'h0000);
        m_start;
        m_wbyte(8'hF5, ack); chk("R4 read header without match nack", ack, 1'b0);
        m_stop;
        m_start;
        m_wbyte(8'hF4, ack);
        m_wbyte(8'hA5, ack);
        m_start;
        m_wbyte(8'hF5, ack); chk("R4 read header after match ack", ack, 1'b1);
        wq(Q);
        chk("R8 scl held for empty send register", scl_oe, 1'b1);
        hr(2'd1, d); chk("R8 hold status", d[4], 1'b1);
        hw(2'd3, 16'h00C3);
        m_rbyte(b, 1'b0); chk("R7 sent byte 10-bit", b, 8'hC3);
        hr(2'd1, d); chk("R9 controller nack flag", d[7], 1'b1);
        m_stop;
    endtask

    task automatic t_read7;
        logic ack;
        logic [7:0] b;
        logic [15:0] d;
        hw(2'd0, 16'h0001); hw(2'd2, 16'h0042); hw(2'd1, 16'h0000);
        hw(2'd3, 16'h0096);
        hr(2'd1, d); chk("R7 send register full flag", d[1], 1'b1);
        m_start;
        m_wbyte(8'h85, ack); chk("R2 read address ack", ack, 1'b1);
        m_rbyte(b, 1'b1); chk("R7 first sent byte", b, 8'h96);
        chk("R8 scl held between bytes", scl_oe, 1'b1);
        hr(2'd1, d); chk("R9 no nack flag after ack", d[7], 1'b0);
        hw(2'd3, 16'h000F);
        m_rbyte(b, 1'b0); chk("R7 second sent byte", b, 8'h0F);
        chk("R9 sda released after nack", sda_oe, 1'b0);
        hr(2'd1, d); chk("R9 nack flag set", d[7], 1'b1);
        m_stop;
        hr(2'd1, d); chk("R9 deselected after stop", d[3], 1'b0);
    endtask

    task automatic t_stretch;
        logic ack;
        logic [15:0] d;
        hw(2'd0, 16'h000D);
        m_start;
        m_wbyte(8'h84, ack);
        m_wbyte(8'h77, ack); chk("R10 byte ack", ack, 1'b1);
        wq(Q);
        chk("R10 scl held after byte", scl_oe, 1'b1);
        hr(2'd0, d); chk("R10 release bit cleared by hardware", d[3], 1'b0);
        hr(2'd3, d); chk("R10 data", d, 16'h0077);
        wq(Q);
        chk("R10 still held before release", scl_oe, 1'b1);
        hw(2'd0, 16'h000D);
        wq(2);
        chk("R10 scl freed after release", scl_oe, 1'b0);
        m_stop;
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        wq(3);
        t_reset;
        t_regs;
        t_disabled;
        t_write7;
        t_mismatch;
        t_overflow;
        t_ten;
        t_ten_read;
        t_read7;
        t_stretch;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule